// File: doc/BRIEF.md
# Dual Serial Device Address Decoder

This block sits behind the receive path of a two-wire serial slave. Once the bit-level logic has collected the address byte of a transaction, it raises a one-cycle strobe with that byte. The decoder compares the upper seven bits against the addresses the slave is set up to answer. On the next clock edge it registers three results: whether to acknowledge, whether the main or the auxiliary side was addressed, and which memory partition to enable.

The auxiliary address is fixed at A0h. The main address is A2h, unless a configuration bit selects a user-programmed byte instead. A second configuration bit chooses the mode. In single-address mode only the main address answers. In dual-address mode A0h also answers and reaches the auxiliary partition. A registered decision holds until the next strobe.

Top module: `dual_addr_dec`

## Requirements
- R1: While reset is asserted, and after it is released, `ack_o`, `sel_main_o` and both bits of `part_en_o` are 0.
- R2: With `main_only_i` = 0, an address byte whose bits [7:1] equal those of A0h, and that does not also hit the main address, gives `ack_o` = 1, `sel_main_o` = 0 and `part_en_o` = 2'b01 (bit 0 is the auxiliary partition).
- R3: With `use_prog_i` = 0, the main address is A2h. A byte whose bits [7:1] equal those of A2h gives `ack_o` = 1, `sel_main_o` = 1 and `part_en_o` = 2'b10 (bit 1 is the main partition). `prog_addr_i` has no effect in this case.
- R4: With `use_prog_i` = 1, the main address is `prog_addr_i`, and A2h is acknowledged only if it matches `prog_addr_i` in bits [7:1].
- R5: With `main_only_i` = 1, A0h is never acknowledged and `part_en_o[0]` is never set. The one exception is a match on the main address itself, which is decoded as main.
- R6: Bit 0 of the address byte (read/write) and bit 0 of the programmed address take no part in the compare.
- R7: When the byte matches both the main address and A0h in dual-address mode, the main partition wins: `sel_main_o` = 1 and `part_en_o` = 2'b10.
- R8: Outputs update on the clock edge that samples `addr_vld_i` = 1. They hold their values on every edge where `addr_vld_i` = 0, whatever the other inputs do.
- R9: A byte that matches no active address gives `ack_o` = 0 and `part_en_o` = 2'b00. In every state `part_en_o` is one-hot or zero, and `sel_main_o` equals `part_en_o[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_byte_i | input | 8 | Received address byte, bit 0 = read/write |
| addr_vld_i | input | 1 | One-cycle strobe, address byte valid |
| main_only_i | input | 1 | 1: answer the main address only; 0: answer main and A0h |
| use_prog_i | input | 1 | 1: main address taken from `prog_addr_i`; 0: main is A2h |
| prog_addr_i | input | 8 | User-programmed main address |
| ack_o | output | 1 | Acknowledge the address phase |
| sel_main_o | output | 1 | 1: main side addressed; 0: auxiliary or none |
| part_en_o | output | 2 | Partition enable, bit 1 main, bit 0 auxiliary |

## Verification
The main and the auxiliary compare can both hit on the same strobe. This happens when the programmed main address equals A0h in dual-address mode, or differs from it only in bit 0. The bench forces this by sweeping every address byte against programmed values of A0h and A1h in both modes. It expects only the main partition to be enabled, with acknowledge set. Every other combination of mode, source and byte in the sweep is compared against an expectation worked out from the address arithmetic alone.

// File: rtl/dual_addr_pkg.sv
package dual_addr_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] AUX_ADDR      = 8'hA0;
  localparam logic [ADDR_W-1:0] MAIN_DEF_ADDR = 8'hA2;

  typedef struct packed {
    logic       ack;
    logic       sel_main;
    logic [1:0] en;   // [1] main, [0] aux
  } dec_res_t;
endpackage

// File: rtl/addr_match.sv
module addr_match #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] rx_i,
  input  logic [W-1:0] ref_i,
  output logic         hit_o
);
  // bit 0 carries direction / is don't-care
  logic unused_lsb;
  assign unused_lsb = rx_i[0] ^ ref_i[0];
  assign hit_o = (rx_i[W-1:1] == ref_i[W-1:1]);
endmodule

// File: rtl/main_addr_sel.sv
module main_addr_sel #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] DEF_ADDR = '0
) (
  input  logic         use_prog_i,
  input  logic [W-1:0] prog_addr_i,
  output logic [W-1:0] main_addr_o
);
  assign main_addr_o = use_prog_i ? prog_addr_i : DEF_ADDR;
endmodule

// File: rtl/dec_prio.sv
module dec_prio
  import dual_addr_pkg::*;
(
  input  logic     hit_main_i,
  input  logic     hit_aux_i,
  input  logic     main_only_i,
  output dec_res_t res_o
);
  logic aux_win;
  always_comb begin
    aux_win      = hit_aux_i && !main_only_i && !hit_main_i;
    res_o.en     = {hit_main_i, aux_win};
    res_o.sel_main = hit_main_i;
    res_o.ack    = hit_main_i || aux_win;
  end

  always_comb begin
    if (hit_main_i || hit_aux_i)
      a_prio_r7: assert (!(res_o.en[1] && res_o.en[0]));
  end
endmodule

// File: rtl/dual_addr_dec.sv
module dual_addr_dec
  import dual_addr_pkg::*;
#(
  parameter int unsigned W = ADDR_W,
  parameter logic [W-1:0] AUX_A  = AUX_ADDR,
  parameter logic [W-1:0] MAIN_A = MAIN_DEF_ADDR
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] addr_byte_i,
  input  logic         addr_vld_i,
  input  logic         main_only_i,
  input  logic         use_prog_i,
  input  logic [W-1:0] prog_addr_i,
  output logic         ack_o,
  output logic         sel_main_o,
  output logic [1:0]   part_en_o
);
  logic [W-1:0] main_addr;
  logic         hit_main, hit_aux;
  dec_res_t     nxt, q;

  main_addr_sel #(.W(W), .DEF_ADDR(MAIN_A)) u_msel (
    .use_prog_i (use_prog_i),
    .prog_addr_i(prog_addr_i),
    .main_addr_o(main_addr)
  );

  addr_match #(.W(W)) u_hit_main (
    .rx_i(addr_byte_i), .ref_i(main_addr), .hit_o(hit_main)
  );

  addr_match #(.W(W)) u_hit_aux (
    .rx_i(addr_byte_i), .ref_i(AUX_A), .hit_o(hit_aux)
  );

  dec_prio u_prio (
    .hit_main_i (hit_main),
    .hit_aux_i  (hit_aux),
    .main_only_i(main_only_i),
    .res_o      (nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q <= '0;
    else if (addr_vld_i) q <= nxt;
  end

  assign ack_o      = q.ack;
  assign sel_main_o = q.sel_main;
  assign part_en_o  = q.en;

  p_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(part_en_o));
  p_sel_en_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (sel_main_o == part_en_o[1]));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_vld_i |=> $stable({ack_o, sel_main_o, part_en_o}));
  p_no_aux_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_vld_i && main_only_i) |=> !part_en_o[0]);
  p_prio_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_vld_i && !main_only_i && use_prog_i &&
     prog_addr_i[W-1:1] == AUX_A[W-1:1] &&
     addr_byte_i[W-1:1] == AUX_A[W-1:1]) |=> (sel_main_o && ack_o));
endmodule

// File: tb/dual_addr_dec_tb.sv
module dual_addr_dec_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] addr_byte = '0;
  logic       addr_vld = 0;
  logic       main_only = 0;
  logic       use_prog = 0;
  logic [7:0] prog_addr = '0;
  logic       ack, sel_main;
  logic [1:0] part_en;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  dual_addr_dec u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_byte_i(addr_byte), .addr_vld_i(addr_vld),
    .main_only_i(main_only), .use_prog_i(use_prog), .prog_addr_i(prog_addr),
    .ack_o(ack), .sel_main_o(sel_main), .part_en_o(part_en)
  );

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {ack,sel,en}=%b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [3:0] model(logic [7:0] a, logic mo, logic up, logic [7:0] pa);
    logic [6:0] m;
    logic hm, ha;
    m  = up ? pa[7:1] : 7'h51;        // A2h >> 1
    hm = (a[7:1] == m);
    ha = (a[7:1] == 7'h50) && !mo;    // A0h >> 1
    if (hm)      return 4'b1110;
    else if (ha) return 4'b1001;
    else         return 4'b0000;
  endfunction

  task automatic strobe(logic [7:0] a, logic mo, logic up, logic [7:0] pa);
    @(negedge clk);
    addr_byte = a; main_only = mo; use_prog = up; prog_addr = pa; addr_vld = 1;
    @(negedge clk);
    addr_vld = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: cycles=%0d expected <100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] progs [4];
    logic [3:0] e;
    string tag;
    progs[0] = 8'hA0; progs[1] = 8'hA1; progs[2] = 8'h3C; progs[3] = 8'hA2;

    #1 check("R1", {ack, sel_main, part_en}, 4'b0000);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", {ack, sel_main, part_en}, 4'b0000);

    // R2 directed
    strobe(8'hA0, 0, 0, 8'h00);
    check("R2", {ack, sel_main, part_en}, 4'b1001);
    // R8 hold: change everything without strobe
    addr_byte = 8'hA2; main_only = 1; prog_addr = 8'hA0; use_prog = 1;
    @(negedge clk);
    check("R8", {ack, sel_main, part_en}, 4'b1001);
    // R3 prog ignored when use_prog=0
    strobe(8'hA3, 1, 0, 8'h10);
    check("R3 R6", {ack, sel_main, part_en}, 4'b1110);
    // R5 directed
    strobe(8'hA1, 1, 0, 8'h10);
    check("R5", {ack, sel_main, part_en}, 4'b0000);
    // R4 directed: A2 rejected with other program
    strobe(8'hA2, 0, 1, 8'h3C);
    check("R4", {ack, sel_main, part_en}, 4'b0000);

    for (int mo = 0; mo < 2; mo++)
      for (int up = 0; up < 2; up++)
        for (int p = 0; p < 4; p++)
          for (int a = 0; a < 256; a++) begin
            strobe(a[7:0], mo[0], up[0], progs[p]);
            e = model(a[7:0], mo[0], up[0], progs[p]);
            if (e[3] && up[0] && a[7:1] == 7'h50 && mo == 0) tag = "R7";
            else if (!e[3])  tag = (mo == 1 && a[7:1] == 7'h50) ? "R5" : "R9";
            else if (up[0])  tag = "R4";
            else if (e[1])   tag = "R3";
            else             tag = "R2";
            if (a[0]) tag = {tag, " R6"};
            check(tag, {ack, sel_main, part_en}, e);
            if (a % 64 == 7) begin
              addr_byte = ~addr_byte; main_only = ~main_only;
              @(negedge clk);
              check("R8", {ack, sel_main, part_en}, e);
            end
          end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule